// File: doc/BRIEF.md
# Single-Wire Daisy-Chain Host Sequencer

This block drives one shared, half-duplex, open-drain line that links a host to a chain of sensor devices. A client hands it one transaction through a valid/ready request port: an operation code, a 5-bit device address, an 8-bit register pointer, 16 bits of write data and, for a global read, the number of devices in the chain. The block then sends the transaction as a run of 10-bit UART-style words grouped into phases. A calibration word comes first, then a command/address word, then a register pointer word (address operations only), and then the data words. Every bit lasts a programmable number of clocks.

For operations that return data, the block stops driving the line once its last word ends and listens for response words. It samples each bit in the middle of its period, counted from the falling edge of the start bit. Each 16-bit value (low byte first) or poll byte is reported on a one-cycle result strobe, together with flags for a low stop bit or a timeout. The FSM states are IDLE, CAL, CMD, PTR, DLO, DHI and RX. IDLE→CAL on an accepted request. CAL→CMD after the calibration word. CMD→PTR for address operations, CMD→RX for a poll, CMD→IDLE for the other commands. PTR→DLO for writes, PTR→RX for reads. DLO→DHI. DHI→IDLE. RX→IDLE on the final value or on a timeout.

Top module: `sw_host_seq`

## Requirements
- R1: After reset and whenever the block is idle, `line_low` is 0 (line released high), `req_ready` is 1 and `rsp_valid` is 0.
- R2: Every transmitted word is a low start bit, 8 data bits least significant bit first, then a high stop bit, each bit lasting `cfg_clks_per_bit` clocks.
- R3: Words go out in phase order: calibration byte 0x55, command/address byte, register pointer byte for address operations (opcodes 0 to 3), then for writes (opcodes 0 and 2) the data low byte followed by the high byte.
- R4: The command/address byte holds global (1) / individual (0) in bit 0, read (1) / write (0) in bit 1, command (1) / address (0) in bit 2, and the address or command code in bits 7:3. Opcodes: 0 individual write, 1 individual read, 2 global write, 3 global read, 4 address-initialize, 5 last-device poll, 6 global reset.
- R5: Command operations send only the calibration and command words, with global=1 and command=1. The codes are 0x0A for address-initialize (write), 0x1C for poll (read) and 0x0D for reset (write).
- R6: An individual read collects two response words, low byte first, and gives one `rsp_valid` strobe carrying the 16-bit value.
- R7: A global read gives `req_count` strobes, one for each device value of two words (a count of 0 counts as 1), and then returns to idle.
- R8: A last-device poll collects one response word and reports it zero-extended to 16 bits.
- R9: If no start bit arrives within `cfg_timeout_bits` bit periods while waiting for a response, the block strobes `rsp_valid` with `rsp_timeout`=1 and data 0, and returns to idle in that same cycle.
- R10: A response word whose stop bit samples low sets `rsp_frame_err` on the strobe of the value that contains it.
- R11: A request is taken only on `req_valid` and `req_ready` together, and `req_ready` is 0 from the next cycle until the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clks_per_bit | input | 16 | Clocks per bit period (at least 4) |
| cfg_timeout_bits | input | 16 | Response timeout in bit periods |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Ready for a request (idle) |
| req_op | input | 3 | Operation code |
| req_addr | input | 5 | Device address |
| req_ptr | input | 8 | Register pointer |
| req_wdata | input | 16 | Write data |
| req_count | input | 5 | Device count for a global read |
| line_i | input | 1 | Sensed line level |
| line_low | output | 1 | Open-drain pull-down enable |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | 16 | Result value |
| rsp_timeout | output | 1 | Result ended by timeout |
| rsp_frame_err | output | 1 | Low stop bit in this value |

## Verification
The hardest situations to reach from the ports are the ones that depend on what a device does on the shared line while the host is listening: a stop bit held low in the middle of a multi-word global read, silence just short of the timeout, and silence that runs past it. The bench contains a device model that pulls the same wired line. The model answers each read with bytes drawn at random, with an occasional corrupted stop bit and a random gap. Directed cases then place a reply a few bit periods before the timeout, give no reply at all, and corrupt the high byte of the second value in a three-device read.

// File: rtl/sw_pkg.sv
package sw_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IWR   = 3'd0,
        OP_IRD   = 3'd1,
        OP_GWR   = 3'd2,
        OP_GRD   = 3'd3,
        OP_AINIT = 3'd4,
        OP_POLL  = 3'd5,
        OP_RESET = 3'd6,
        OP_SPARE = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CAL, S_CMD, S_PTR, S_DLO, S_DHI, S_RX
    } state_e;

    localparam logic [BYTE_W-1:0] CAL_BYTE   = 8'h55;
    localparam logic [ADDR_W-1:0] CODE_AINIT = 5'h0A;
    localparam logic [ADDR_W-1:0] CODE_POLL  = 5'h1C;
    localparam logic [ADDR_W-1:0] CODE_RESET = 5'h0D;

    // flags: bit2 command, bit1 read, bit0 global
    function automatic logic [BYTE_W-1:0] cmd_byte(op_e op, logic [ADDR_W-1:0] addr);
        unique case (op)
            OP_IWR:   return {addr, 3'b000};
            OP_IRD:   return {addr, 3'b010};
            OP_GWR:   return {addr, 3'b001};
            OP_GRD:   return {addr, 3'b011};
            OP_AINIT: return {CODE_AINIT, 3'b101};
            OP_POLL:  return {CODE_POLL, 3'b111};
            default:  return {CODE_RESET, 3'b101};
        endcase
    endfunction
endpackage

// File: rtl/sw_tx.sv
module sw_tx #(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CPB_W-1:0] cpb,
    input  logic             start,
    input  logic [7:0]       tx_data,
    output logic             ready,
    output logic             done,
    output logic             line_low
);
    localparam logic [CPB_W-1:0] ONE = 1;
    logic             busy;
    logic [CPB_W-1:0] cnt;
    logic [3:0]       idx;
    logic [9:0]       sh;
    logic             bit_end;

    assign bit_end  = (cnt == cpb - ONE);
    assign ready    = !busy;
    assign done     = busy && bit_end && (idx == 4'd9);
    assign line_low = busy && !sh[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            idx  <= '0;
            sh   <= '1;
        end else if (start && !busy) begin
            busy <= 1'b1;
            sh   <= {1'b1, tx_data, 1'b0};
            cnt  <= '0;
            idx  <= '0;
        end else if (busy) begin
            if (bit_end) begin
                cnt <= '0;
                if (idx == 4'd9) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 4'd1;
                    sh  <= {1'b1, sh[9:1]};
                end
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/sw_rx.sv
module sw_rx #(
    parameter int CPB_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line_i,
    input  logic [CPB_W-1:0] cpb,
    output logic             busy,
    output logic             vld,
    output logic [7:0]       data,
    output logic             ferr
);
    localparam logic [CPB_W-1:0] ONE = 1;
    logic [1:0]       sync;
    logic             armed;
    logic [CPB_W-1:0] cnt;
    logic [3:0]       idx;
    logic [7:0]       sh;
    logic [CPB_W-1:0] target;
    logic             s;

    assign s      = sync[1];
    assign target = (idx == 4'd0) ? ((cpb >> 1) - ONE) : (cpb - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync  <= 2'b11;
            armed <= 1'b0;
            busy  <= 1'b0;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            vld   <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
        end else begin
            sync <= {sync[0], line_i};
            vld  <= 1'b0;
            if (!busy) begin
                if (s) begin
                    armed <= 1'b1;
                end else if (en && armed) begin
                    busy  <= 1'b1;
                    armed <= 1'b0;
                    cnt   <= '0;
                    idx   <= '0;
                end
            end else if (cnt == target) begin
                cnt <= '0;
                idx <= idx + 4'd1;
                if (idx == 4'd0) begin
                    if (s) busy <= 1'b0;          // glitch, not a start bit
                end else if (idx == 4'd9) begin
                    busy <= 1'b0;
                    vld  <= 1'b1;
                    data <= sh;
                    ferr <= !s;
                end else begin
                    sh <= {s, sh[7:1]};
                end
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/sw_host_seq.sv
module sw_host_seq
    import sw_pkg::*;
#(
    parameter int CPB_W = 16,
    parameter int TO_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPB_W-1:0]      cfg_clks_per_bit,
    input  logic [TO_W-1:0]       cfg_timeout_bits,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [OP_W-1:0]       req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [BYTE_W-1:0]     req_ptr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [ADDR_W-1:0]     req_count,
    input  logic                  line_i,
    output logic                  line_low,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_data,
    output logic                  rsp_timeout,
    output logic                  rsp_frame_err
);
    localparam logic [CPB_W-1:0]  C_ONE = 1;
    localparam logic [TO_W-1:0]   T_ONE = 1;
    localparam logic [ADDR_W-1:0] A_ONE = 1;

    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q, remain_q;
    logic [BYTE_W-1:0] ptr_q, lo_q;
    logic [DATA_W-1:0] wdata_q;
    logic              half_q, ferr_q;
    logic [CPB_W-1:0]  clk_cnt;
    logic [TO_W-1:0]   bit_cnt;

    logic              tx_start, tx_ready, tx_done, rx_en;
    logic [BYTE_W-1:0] tx_byte;
    logic              rx_busy, rx_vld, rx_ferr;
    logic [BYTE_W-1:0] rx_data;
    logic              is_cmd, is_write, tick, to_hit, last_val;

    sw_tx #(.CPB_W(CPB_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cpb(cfg_clks_per_bit), .start(tx_start),
        .tx_data(tx_byte), .ready(tx_ready), .done(tx_done), .line_low(line_low));

    sw_rx #(.CPB_W(CPB_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .line_i(line_i), .cpb(cfg_clks_per_bit),
        .busy(rx_busy), .vld(rx_vld), .data(rx_data), .ferr(rx_ferr));

    assign is_cmd   = op_q[2];
    assign is_write = (op_q == OP_IWR) || (op_q == OP_GWR);
    assign tick     = (clk_cnt == cfg_clks_per_bit - C_ONE);
    assign to_hit   = (state_q == S_RX) && !rx_busy && !rx_vld && tick &&
                      (bit_cnt == cfg_timeout_bits - T_ONE);
    assign last_val = (op_q == OP_POLL) || (half_q && remain_q == A_ONE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = S_CAL;
            S_CAL:  if (tx_done) state_d = S_CMD;
            S_CMD:  if (tx_done) state_d = !is_cmd ? S_PTR :
                                           (op_q == OP_POLL) ? S_RX : S_IDLE;
            S_PTR:  if (tx_done) state_d = is_write ? S_DLO : S_RX;
            S_DLO:  if (tx_done) state_d = S_DHI;
            S_DHI:  if (tx_done) state_d = S_IDLE;
            S_RX:   if (to_hit || (rx_vld && last_val)) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rx_en     = (state_q == S_RX);
        tx_start  = 1'b0;
        tx_byte   = CAL_BYTE;
        unique case (state_q)
            S_CAL: begin tx_start = tx_ready; tx_byte = CAL_BYTE; end
            S_CMD: begin tx_start = tx_ready; tx_byte = cmd_byte(op_q, addr_q); end
            S_PTR: begin tx_start = tx_ready; tx_byte = ptr_q; end
            S_DLO: begin tx_start = tx_ready; tx_byte = wdata_q[7:0]; end
            S_DHI: begin tx_start = tx_ready; tx_byte = wdata_q[15:8]; end
            default: ;
        endcase
    end

    // request capture, response assembly, timeout counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IWR; addr_q <= '0; ptr_q <= '0; wdata_q <= '0;
            remain_q <= '0; half_q <= 1'b0; ferr_q <= 1'b0; lo_q <= '0;
            clk_cnt <= '0; bit_cnt <= '0;
            rsp_valid <= 1'b0; rsp_data <= '0; rsp_timeout <= 1'b0; rsp_frame_err <= 1'b0;
        end else begin
            rsp_valid     <= 1'b0;
            rsp_timeout   <= 1'b0;
            rsp_frame_err <= 1'b0;
            if (state_q == S_IDLE && req_valid) begin
                op_q     <= op_e'(req_op);
                addr_q   <= req_addr;
                ptr_q    <= req_ptr;
                wdata_q  <= req_wdata;
                remain_q <= (op_e'(req_op) == OP_GRD && req_count != '0) ? req_count : A_ONE;
                half_q   <= 1'b0;
                ferr_q   <= 1'b0;
            end
            if (state_q != S_RX || rx_busy || rx_vld) begin
                clk_cnt <= '0;
                bit_cnt <= '0;
            end else if (tick) begin
                clk_cnt <= '0;
                bit_cnt <= bit_cnt + T_ONE;
            end else begin
                clk_cnt <= clk_cnt + C_ONE;
            end
            if (state_q == S_RX) begin
                if (rx_vld) begin
                    if (op_q == OP_POLL) begin
                        rsp_valid     <= 1'b1;
                        rsp_data      <= {8'h00, rx_data};
                        rsp_frame_err <= rx_ferr;
                    end else if (!half_q) begin
                        lo_q   <= rx_data;
                        ferr_q <= rx_ferr;
                        half_q <= 1'b1;
                    end else begin
                        rsp_valid     <= 1'b1;
                        rsp_data      <= {rx_data, lo_q};
                        rsp_frame_err <= ferr_q | rx_ferr;
                        half_q        <= 1'b0;
                        remain_q      <= remain_q - A_ONE;
                    end
                end else if (to_hit) begin
                    rsp_valid   <= 1'b1;
                    rsp_data    <= '0;
                    rsp_timeout <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sw_host_seq_chk.sv
module sw_host_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic line_low,
    input logic rsp_valid,
    input logic rsp_timeout,
    input logic rsp_frame_err
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !line_low);

    assert_start_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_low) |-> !req_ready);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_timeout_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> rsp_valid);

    assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_timeout |-> req_ready);

    assert_frame_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_frame_err |-> rsp_valid);
endmodule

bind sw_host_seq sw_host_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .line_low(line_low), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
    .rsp_frame_err(rsp_frame_err));

// File: tb/sim_sw_host_seq.sv
module sim_sw_host_seq;
    localparam int CPB = 8;
    localparam int TOB = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [4:0]  req_addr = '0;
    logic [7:0]  req_ptr = '0;
    logic [15:0] req_wdata = '0;
    logic [4:0]  req_count = '0;
    logic        line_i, line_low, dev_low = 1'b0;
    logic        rsp_valid, rsp_timeout, rsp_frame_err;
    logic [15:0] rsp_data;

    int checks = 0;
    int errors = 0;
    logic [7:0]  txq[$];
    logic [17:0] rq[$];
    logic [7:0]  resp_b[$];
    bit          resp_ok[$];

    always #10 clk = ~clk;
    assign line_i = ~(line_low | dev_low);

    sw_host_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_clks_per_bit(16'(CPB)), .cfg_timeout_bits(16'(TOB)),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_ptr(req_ptr), .req_wdata(req_wdata),
        .req_count(req_count), .line_i(line_i), .line_low(line_low),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_timeout(rsp_timeout), .rsp_frame_err(rsp_frame_err));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] exp_cmd(input logic [2:0] op, input logic [4:0] a);
        case (op)
            3'd0: return {a, 3'b000};
            3'd1: return {a, 3'b010};
            3'd2: return {a, 3'b001};
            3'd3: return {a, 3'b011};
            3'd4: return {5'h0A, 3'b101};
            3'd5: return {5'h1C, 3'b111};
            default: return {5'h0D, 3'b101};
        endcase
    endfunction

    // line monitor: decodes host words at mid-bit (R2)
    initial begin : mon
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (line_low) begin
                repeat (CPB/2 - 1) @(negedge clk);
                chk(line_low == 1'b1, "R2", "start bit low", line_low, 1);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = ~line_low;
                end
                repeat (CPB) @(negedge clk);
                chk(line_low == 1'b0, "R2", "stop bit high", line_low, 0);
                txq.push_back(b);
            end
        end
    end

    always @(negedge clk)
        if (rsp_valid) rq.push_back({rsp_timeout, rsp_frame_err, rsp_data});

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        dev_low = 1'b1;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            dev_low = ~b[i];
            repeat (CPB) @(negedge clk);
        end
        dev_low = ~good_stop;
        repeat (CPB) @(negedge clk);
        dev_low = 1'b0;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic run_txn(input logic [2:0] op, input logic [4:0] a, input logic [7:0] p,
                           input logic [15:0] wd, input logic [4:0] cnt, input int gap_bits);
        logic [7:0]  exp_tx[$];
        logic [17:0] exp_rs[$];
        string       rtag;
        int          w;
        int          nval;
        txq.delete();
        rq.delete();
        exp_tx.push_back(8'h55);
        exp_tx.push_back(exp_cmd(op, a));
        if (op < 3'd4) exp_tx.push_back(p);
        if (op == 3'd0 || op == 3'd2) begin
            exp_tx.push_back(wd[7:0]);
            exp_tx.push_back(wd[15:8]);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_ptr = p;
        req_wdata = wd; req_count = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "ready drops after accept", req_ready, 0);
        w = 0;
        while (txq.size() < exp_tx.size() && w < 5000) begin @(negedge clk); w++; end
        repeat (CPB) @(negedge clk);
        chk(txq.size() == exp_tx.size(), (op >= 3'd4) ? "R5" : "R3", "word count",
            txq.size(), exp_tx.size());
        for (int i = 0; i < exp_tx.size() && i < txq.size(); i++)
            chk(txq[i] == exp_tx[i], (i == 1) ? ((op >= 3'd4) ? "R5" : "R4") : "R3",
                $sformatf("word %0d", i), txq[i], exp_tx[i]);
        rtag = "R6";
        if (op == 3'd1 || op == 3'd3 || op == 3'd5) begin
            if (op == 3'd3) rtag = "R7";
            if (op == 3'd5) rtag = "R8";
            if (resp_b.size() == 0) begin
                exp_rs.push_back({2'b10, 16'h0});
                rtag = "R9";
            end else if (op == 3'd5) begin
                exp_rs.push_back({1'b0, !resp_ok[0], 8'h00, resp_b[0]});
            end else begin
                nval = (op == 3'd1) ? 1 : ((cnt == 0) ? 1 : int'(cnt));
                for (int v = 0; v < nval; v++)
                    exp_rs.push_back({1'b0, !(resp_ok[2*v] && resp_ok[2*v+1]),
                                      resp_b[2*v+1], resp_b[2*v]});
            end
            foreach (exp_rs[k]) if (exp_rs[k][16]) rtag = "R10";
            repeat (gap_bits * CPB) @(negedge clk);
            foreach (resp_b[k]) send_byte(resp_b[k], resp_ok[k]);
        end
        w = 0;
        while (!req_ready && w < 20000) begin @(negedge clk); w++; end
        repeat (2) @(negedge clk);
        chk(req_ready && !line_low, "R1", "idle and released after txn",
            {req_ready, line_low}, 2'b10);
        chk(rq.size() == exp_rs.size(), rtag, "result count", rq.size(), exp_rs.size());
        for (int i = 0; i < exp_rs.size() && i < rq.size(); i++)
            chk(rq[i] == exp_rs[i], rtag, $sformatf("result %0d", i), rq[i], exp_rs[i]);
        resp_b.delete();
        resp_ok.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd1357);
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1 && line_low == 1'b0 && rsp_valid == 1'b0, "R1", "reset state",
            {req_ready, line_low, rsp_valid}, 3'b100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(line_low == 1'b0, "R1", "line idle high", line_low, 0);

        // directed cases
        run_txn(3'd0, 5'd3, 8'h12, 16'hBEEF, 5'd0, 0);                       // R3 R4
        run_txn(3'd2, 5'd0, 8'h01, 16'h0A5C, 5'd0, 0);
        run_txn(3'd4, 5'd0, 8'h00, 16'h0000, 5'd0, 0);                       // R5
        run_txn(3'd6, 5'd0, 8'h00, 16'h0000, 5'd0, 0);
        resp_b = '{8'h34, 8'h12}; resp_ok = '{1, 1};
        run_txn(3'd1, 5'd7, 8'h00, 16'h0, 5'd0, 3);                          // R6
        resp_b = '{8'h07}; resp_ok = '{1};
        run_txn(3'd5, 5'd0, 8'h00, 16'h0, 5'd0, 2);                          // R8
        run_txn(3'd1, 5'd2, 8'h00, 16'h0, 5'd0, 0);                          // R9 no reply
        resp_b = '{8'hC3, 8'h5A}; resp_ok = '{1, 1};
        run_txn(3'd1, 5'd2, 8'h00, 16'h0, 5'd0, TOB - 3);                    // near timeout
        resp_b = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}; resp_ok = '{1, 1, 1, 0, 1, 1};
        run_txn(3'd3, 5'd0, 8'h02, 16'h0, 5'd3, 1);                          // R7 R10

        // random traffic
        for (int t = 0; t < 24; t++) begin
            logic [2:0] op;
            logic [4:0] cnt;
            int nb;
            op  = 3'($urandom_range(0, 6));
            cnt = 5'($urandom_range(1, 3));
            nb  = (op == 3'd1) ? 2 : (op == 3'd3) ? 2 * int'(cnt) : (op == 3'd5) ? 1 : 0;
            for (int k = 0; k < nb; k++) begin
                resp_b.push_back(8'($urandom));
                resp_ok.push_back($urandom_range(0, 7) != 0);
            end
            run_txn(op, 5'($urandom), 8'($urandom), 16'($urandom), cnt,
                    int'($urandom_range(1, 5)));
        end
        finish_run();
    end
endmodule